// File: doc/BRIEF.md
# Pin Function Multiplexer with Sleep Force Override

This block sits between a general-purpose I/O register bank, three on-chip peripheral functions and a row of pads. For every pin it decides which source drives the pad: the GPIO bank, or peripheral function A, B or C. The choice is held in two independent one-bit-per-pin select registers. Clearing both selects GPIO. Setting only the first selects A, setting only the second selects B, and setting both selects C.

A third register, the sleep-keep mask, works together with a force input that the power controller raises while the chip sleeps. A pin whose mask bit is clear is pulled back to GPIO control for as long as the force input is high, and its wake detection is enabled. A pin whose mask bit is set keeps its normal source through sleep and reports no wake enable. When the force input drops, every pin returns at once to the source its select bits name. The path from the registers, the force input and the source inputs to the pad controls is purely combinational. Only register writes take a clock.

Top module: `pinmux_sleep_force`

## Requirements
- R1: The pin mode is {select-B bit, select-A bit}: 00 selects GPIO, 01 (A bit only) selects function A, 10 (B bit only) selects function B, and 11 selects function C. With the force input low, pad_out and pad_oe of each pin come from the selected source.
- R2: After reset both select registers read all zeros, the sleep-keep mask reads all ones, and every pad follows the GPIO bank.
- R3: A write with cfg_we high loads cfg_wdata into the register named by cfg_addr: 0 is select A, 1 is select B, 2 is the sleep-keep mask. The new value takes effect after the next rising clock edge. A write to address 3 changes no register.
- R4: cfg_rdata combinationally returns the register named by cfg_addr. Address 3 reads as zero.
- R5: While io_force is high, a pin whose sleep-keep bit is 0 is driven from the GPIO bank, whatever its select bits hold.
- R6: While io_force is high, a pin whose sleep-keep bit is 1 keeps the source its select bits name.
- R7: When io_force returns low, every pin goes back to its selected source in the same cycle, with no clock edge needed.
- R8: In GPIO mode, pad_out, pad_oe, pad_pull_en and pad_pull_up equal the GPIO bank's bits. In any peripheral mode, pad_pull_en and pad_pull_up are 0.
- R9: wake_en of a pin is 1 exactly when io_force is high and the pin's sleep-keep bit is 0.
- R10: Changes on the GPIO bank or peripheral inputs reach the pad outputs without a clock edge.
- R11: Each pin is muxed independently, so different pins may sit in different modes at the same time, including the first and last pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 select A, 1 select B, 2 sleep-keep mask, 3 reserved |
| cfg_wdata | input | NUM_PINS | Write data |
| cfg_rdata | output | NUM_PINS | Read data for cfg_addr |
| io_force | input | 1 | Sleep force from the power controller |
| gpio_out | input | NUM_PINS | GPIO bank output data |
| gpio_oe | input | NUM_PINS | GPIO bank output enable |
| gpio_pull_en | input | NUM_PINS | GPIO bank pull enable |
| gpio_pull_up | input | NUM_PINS | GPIO bank pull direction, 1 means up |
| fa_out | input | NUM_PINS | Function A output data |
| fa_oe | input | NUM_PINS | Function A output enable |
| fb_out | input | NUM_PINS | Function B output data |
| fb_oe | input | NUM_PINS | Function B output enable |
| fc_out | input | NUM_PINS | Function C output data |
| fc_oe | input | NUM_PINS | Function C output enable |
| pad_out | output | NUM_PINS | Pad output data |
| pad_oe | output | NUM_PINS | Pad output enable |
| pad_pull_en | output | NUM_PINS | Pad pull enable |
| pad_pull_up | output | NUM_PINS | Pad pull direction |
| wake_en | output | NUM_PINS | Per-pin wake detection enable |

## Verification
The bench builds the block at its default width of 32 pins. At that width pins 0 and 31 are real pins, so a mask that keeps only the two edge pins shows that the per-pin generate covers both ends of the vector. Each source drives a fixed (out, oe) pair that differs from every other source, so each pin's mode can be read directly off the pads. A second GPIO pattern and live toggling of the force input, with no clock edge in between, show that the pad path is combinational.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

    localparam int CFG_ADDR_W = 2;
    localparam int NUM_FUNCS  = 3;

    // configuration register addresses
    typedef enum logic [CFG_ADDR_W-1:0] {
        REG_SEL_A  = 2'd0,
        REG_SEL_B  = 2'd1,
        REG_SLEEP  = 2'd2,
        REG_RSVD   = 2'd3
    } cfg_reg_e;

    // pin mode: bit0 is the A select bit, bit1 the B select bit
    typedef enum logic [1:0] {
        MODE_GPIO = 2'b00,
        MODE_FA   = 2'b01,
        MODE_FB   = 2'b10,
        MODE_FC   = 2'b11
    } mux_mode_e;

endpackage

// File: rtl/pinmux_cfg_regs.sv
module pinmux_cfg_regs
    import pinmux_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [NUM_PINS-1:0]   cfg_wdata,
    output logic [NUM_PINS-1:0]   cfg_rdata,
    output logic [NUM_PINS-1:0]   sel_a,
    output logic [NUM_PINS-1:0]   sel_b,
    output logic [NUM_PINS-1:0]   slp_keep
);

    typedef struct packed {
        logic [NUM_PINS-1:0] sel_a;
        logic [NUM_PINS-1:0] sel_b;
        logic [NUM_PINS-1:0] keep;
    } cfg_state_t;

    localparam cfg_state_t RST_STATE = '{sel_a: '0, sel_b: '0, keep: '1};

    cfg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (cfg_we) begin
            case (cfg_reg_e'(cfg_addr))
                REG_SEL_A: state_d.sel_a = cfg_wdata;
                REG_SEL_B: state_d.sel_b = cfg_wdata;
                REG_SLEEP: state_d.keep  = cfg_wdata;
                default:   state_d       = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RST_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        case (cfg_reg_e'(cfg_addr))
            REG_SEL_A: cfg_rdata = state_q.sel_a;
            REG_SEL_B: cfg_rdata = state_q.sel_b;
            REG_SLEEP: cfg_rdata = state_q.keep;
            default:   cfg_rdata = '0;
        endcase
    end

    assign sel_a    = state_q.sel_a;
    assign sel_b    = state_q.sel_b;
    assign slp_keep = state_q.keep;

    // R2: reset leaves GPIO selected everywhere and every pin kept
    a_r2_reset_values: assert property (@(posedge clk)
        !rst_n |=> (sel_a == '0 && sel_b == '0 && slp_keep == '1));

    // R3: no write strobe, no register change
    a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(state_q));

    // R3: reserved address leaves every register alone
    a_r3_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == REG_RSVD) |=> $stable(state_q));

    // R3: sleep mask write lands one edge later
    a_r3_keep_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == REG_SLEEP) |=> slp_keep == $past(cfg_wdata));

endmodule

// File: rtl/pinmux_pin_sel.sv
module pinmux_pin_sel
    import pinmux_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                     io_force,
    input  logic [NUM_PINS-1:0]      sel_a,
    input  logic [NUM_PINS-1:0]      sel_b,
    input  logic [NUM_PINS-1:0]      slp_keep,
    output mux_mode_e [NUM_PINS-1:0] pin_mode,
    output logic [NUM_PINS-1:0]      wake_en
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic forced;
        assign forced = io_force & ~slp_keep[p];

        always_comb begin
            if (forced) begin
                pin_mode[p] = MODE_GPIO;
            end else begin
                pin_mode[p] = mux_mode_e'({sel_b[p], sel_a[p]});
            end
        end

        assign wake_en[p] = forced;
    end

endmodule

// File: rtl/pinmux_pad_sel.sv
module pinmux_pad_sel
    import pinmux_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  mux_mode_e [NUM_PINS-1:0]                 pin_mode,
    input  logic [NUM_PINS-1:0]                      gpio_out,
    input  logic [NUM_PINS-1:0]                      gpio_oe,
    input  logic [NUM_PINS-1:0]                      gpio_pull_en,
    input  logic [NUM_PINS-1:0]                      gpio_pull_up,
    input  logic [NUM_FUNCS-1:0][NUM_PINS-1:0]       fn_out,
    input  logic [NUM_FUNCS-1:0][NUM_PINS-1:0]       fn_oe,
    output logic [NUM_PINS-1:0]                      pad_out,
    output logic [NUM_PINS-1:0]                      pad_oe,
    output logic [NUM_PINS-1:0]                      pad_pull_en,
    output logic [NUM_PINS-1:0]                      pad_pull_up
);

    localparam int FN_IDX_W = (NUM_FUNCS > 1) ? $clog2(NUM_FUNCS) : 1;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
        logic [FN_IDX_W-1:0] fn_idx;

        // function A sits at mode 1, so function k is mode k+1
        assign fn_idx = FN_IDX_W'(pin_mode[p] - 2'd1);

        always_comb begin
            if (pin_mode[p] == MODE_GPIO) begin
                pad_out[p]     = gpio_out[p];
                pad_oe[p]      = gpio_oe[p];
                pad_pull_en[p] = gpio_pull_en[p];
                pad_pull_up[p] = gpio_pull_up[p];
            end else begin
                pad_out[p]     = fn_out[fn_idx][p];
                pad_oe[p]      = fn_oe[fn_idx][p];
                pad_pull_en[p] = 1'b0;
                pad_pull_up[p] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/pinmux_sleep_force.sv
module pinmux_sleep_force
    import pinmux_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [NUM_PINS-1:0]   cfg_wdata,
    output logic [NUM_PINS-1:0]   cfg_rdata,
    input  logic                  io_force,
    input  logic [NUM_PINS-1:0]   gpio_out,
    input  logic [NUM_PINS-1:0]   gpio_oe,
    input  logic [NUM_PINS-1:0]   gpio_pull_en,
    input  logic [NUM_PINS-1:0]   gpio_pull_up,
    input  logic [NUM_PINS-1:0]   fa_out,
    input  logic [NUM_PINS-1:0]   fa_oe,
    input  logic [NUM_PINS-1:0]   fb_out,
    input  logic [NUM_PINS-1:0]   fb_oe,
    input  logic [NUM_PINS-1:0]   fc_out,
    input  logic [NUM_PINS-1:0]   fc_oe,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [NUM_PINS-1:0]   pad_pull_en,
    output logic [NUM_PINS-1:0]   pad_pull_up,
    output logic [NUM_PINS-1:0]   wake_en
);

    logic [NUM_PINS-1:0]                sel_a, sel_b, slp_keep;
    mux_mode_e [NUM_PINS-1:0]           pin_mode;
    logic [NUM_FUNCS-1:0][NUM_PINS-1:0] fn_out, fn_oe;

    assign fn_out = {fc_out, fb_out, fa_out};
    assign fn_oe  = {fc_oe,  fb_oe,  fa_oe};

    pinmux_cfg_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .sel_a     (sel_a),
        .sel_b     (sel_b),
        .slp_keep  (slp_keep)
    );

    pinmux_pin_sel #(.NUM_PINS(NUM_PINS)) u_pin_sel (
        .io_force (io_force),
        .sel_a    (sel_a),
        .sel_b    (sel_b),
        .slp_keep (slp_keep),
        .pin_mode (pin_mode),
        .wake_en  (wake_en)
    );

    pinmux_pad_sel #(.NUM_PINS(NUM_PINS)) u_pad_sel (
        .pin_mode     (pin_mode),
        .gpio_out     (gpio_out),
        .gpio_oe      (gpio_oe),
        .gpio_pull_en (gpio_pull_en),
        .gpio_pull_up (gpio_pull_up),
        .fn_out       (fn_out),
        .fn_oe        (fn_oe),
        .pad_out      (pad_out),
        .pad_oe       (pad_oe),
        .pad_pull_en  (pad_pull_en),
        .pad_pull_up  (pad_pull_up)
    );

    // R9: a kept pin never asks for wake, and nothing wakes without force
    a_r9_wake_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_en & slp_keep) == '0);
    a_r9_wake_needs_force: assert property (@(posedge clk) disable iff (!rst_n)
        !io_force |-> wake_en == '0);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
        // R5: forced pin is driven by the GPIO bank
        a_r5_forced_to_gpio: assert property (@(posedge clk) disable iff (!rst_n)
            (io_force && !slp_keep[p]) |->
                (pad_out[p] == gpio_out[p] && pad_oe[p] == gpio_oe[p]));
        // R6: kept pin with both select bits stays on function C
        a_r6_kept_on_fc: assert property (@(posedge clk) disable iff (!rst_n)
            (slp_keep[p] && sel_a[p] && sel_b[p]) |->
                (pad_out[p] == fc_out[p] && pad_oe[p] == fc_oe[p]));
        // R8: peripheral modes leave pulls off
        a_r8_no_pull_on_fn: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_mode[p] != MODE_GPIO) |-> (!pad_pull_en[p] && !pad_pull_up[p]));
    end

endmodule

// File: tb/tb_pinmux_sleep_force.sv
module tb_pinmux_sleep_force;

    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_addr = 2'd0;
    logic [N-1:0] cfg_wdata = '0;
    logic [N-1:0] cfg_rdata;
    logic         io_force = 1'b0;
    logic [N-1:0] gpio_out, gpio_oe, gpio_pull_en, gpio_pull_up;
    logic [N-1:0] fa_out, fa_oe, fb_out, fb_oe, fc_out, fc_oe;
    logic [N-1:0] pad_out, pad_oe, pad_pull_en, pad_pull_up, wake_en;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    pinmux_sleep_force #(.NUM_PINS(N)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_force(io_force),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe), .gpio_pull_en(gpio_pull_en),
        .gpio_pull_up(gpio_pull_up), .fa_out(fa_out), .fa_oe(fa_oe),
        .fb_out(fb_out), .fb_oe(fb_oe), .fc_out(fc_out), .fc_oe(fc_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
        .pad_pull_up(pad_pull_up), .wake_en(wake_en)
    );

    typedef struct packed {
        logic [N-1:0] a;
        logic [N-1:0] b;
        logic [N-1:0] keep;
        logic         force_on;
    } vec_t;

    typedef struct packed {
        logic [N-1:0] out;
        logic [N-1:0] oe;
        logic [N-1:0] pen;
        logic [N-1:0] pup;
        logic [N-1:0] wake;
    } pads_t;

    // R1 all four modes, R11 mixed pins, R5/R6/R9 under force, edge pins 0 and 31
    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{a: 32'h0000_0000, b: 32'h0000_0000, keep: 32'hFFFF_FFFF, force_on: 1'b0},
        '{a: 32'hFFFF_FFFF, b: 32'h0000_0000, keep: 32'hFFFF_FFFF, force_on: 1'b0},
        '{a: 32'h0000_0000, b: 32'hFFFF_FFFF, keep: 32'hFFFF_FFFF, force_on: 1'b0},
        '{a: 32'hFFFF_FFFF, b: 32'hFFFF_FFFF, keep: 32'hFFFF_FFFF, force_on: 1'b0},
        '{a: 32'h0F0F_00FF, b: 32'h00FF_0F0F, keep: 32'hFFFF_0000, force_on: 1'b0},
        '{a: 32'h0F0F_00FF, b: 32'h00FF_0F0F, keep: 32'hFFFF_0000, force_on: 1'b1},
        '{a: 32'hFFFF_FFFF, b: 32'hFFFF_FFFF, keep: 32'h8000_0001, force_on: 1'b1},
        '{a: 32'hFFFF_FFFF, b: 32'hFFFF_FFFF, keep: 32'h0000_0000, force_on: 1'b1}
    };

    // expected pads from the requirement text, pin by pin
    function automatic pads_t expect_pads(vec_t v);
        pads_t e;
        for (int i = 0; i < N; i++) begin
            logic forced;
            forced = v.force_on && !v.keep[i];
            e.wake[i] = forced;
            e.pen[i] = 1'b0;
            e.pup[i] = 1'b0;
            if (forced || (!v.a[i] && !v.b[i])) begin
                e.out[i] = gpio_out[i]; e.oe[i] = gpio_oe[i];
                e.pen[i] = gpio_pull_en[i]; e.pup[i] = gpio_pull_up[i];
            end else if (v.a[i] && !v.b[i]) begin
                e.out[i] = fa_out[i]; e.oe[i] = fa_oe[i];
            end else if (!v.a[i] && v.b[i]) begin
                e.out[i] = fb_out[i]; e.oe[i] = fb_oe[i];
            end else begin
                e.out[i] = fc_out[i]; e.oe[i] = fc_oe[i];
            end
        end
        return e;
    endfunction

    task automatic check(string req, logic [N*5-1:0] got, logic [N*5-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check32(string req, logic [N-1:0] got, logic [N-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cfg_write(logic [1:0] addr, logic [N-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic read_reg(logic [1:0] addr, output logic [N-1:0] data);
        cfg_addr = addr;
        #0.5;
        data = cfg_rdata;
    endtask

    function automatic logic [N*5-1:0] pads_now();
        return {pad_out, pad_oe, pad_pull_en, pad_pull_up, wake_en};
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [N-1:0] rd;
        vec_t v;
        // every source has its own (out, oe) pair on every pin
        gpio_out = '0;  gpio_oe = '0;
        gpio_pull_en = '1; gpio_pull_up = 32'h5555_5555;
        fa_out = '1; fa_oe = '0;
        fb_out = '0; fb_oe = '1;
        fc_out = '1; fc_oe = '1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        read_reg(2'd0, rd); check32("R2 sel A reset", rd, '0);
        read_reg(2'd1, rd); check32("R2 sel B reset", rd, '0);
        read_reg(2'd2, rd); check32("R2 keep reset", rd, '1);
        v = '{a: '0, b: '0, keep: '1, force_on: 1'b0};
        check("R2 pads follow GPIO", pads_now(), expect_pads(v));

        // vector table
        for (int k = 0; k < NVEC; k++) begin
            v = VECS[k];
            cfg_write(2'd0, v.a);
            cfg_write(2'd1, v.b);
            cfg_write(2'd2, v.keep);
            io_force = v.force_on;
            #0.5;
            check($sformatf("R1/R5/R6/R9/R11 vector %0d", k), pads_now(), expect_pads(v));
            read_reg(2'd0, rd); check32($sformatf("R4 read sel A vec %0d", k), rd, v.a);
            read_reg(2'd1, rd); check32($sformatf("R4 read sel B vec %0d", k), rd, v.b);
            read_reg(2'd2, rd); check32($sformatf("R4 read keep vec %0d", k), rd, v.keep);
        end

        // R7: force drops, pins return without a clock edge (all C, nothing kept)
        @(negedge clk);
        io_force = 1'b0;
        #0.5;
        v.force_on = 1'b0;
        check("R7 force release", pads_now(), expect_pads(v));
        io_force = 1'b1;
        #0.5;
        v.force_on = 1'b1;
        check("R5 force reapplied", pads_now(), expect_pads(v));

        // R8/R10: new GPIO pattern reaches pads with no clock edge
        gpio_out = 32'hC3C3_A5A5; gpio_oe = 32'h0FF0_1234;
        gpio_pull_en = 32'h1357_9BDF; gpio_pull_up = 32'hFEDC_BA98;
        #0.5;
        check("R8/R10 GPIO passthrough", pads_now(), expect_pads(v));
        fc_out = 32'h0000_0000;
        io_force = 1'b0;
        #0.5;
        v.force_on = 1'b0;
        check("R8/R10 function C live, pulls off", pads_now(), expect_pads(v));

        // R3: write is not visible before the edge, lands after it
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 32'h1234_5678;
        #0.5;
        check32("R3 no change before edge", cfg_rdata, 32'hFFFF_FFFF);
        @(negedge clk);
        cfg_we = 1'b0;
        read_reg(2'd0, rd); check32("R3 write after edge", rd, 32'h1234_5678);

        // R3/R4: reserved address write ignored, reads zero
        cfg_write(2'd3, 32'hDEAD_BEEF);
        read_reg(2'd3, rd); check32("R4 reserved reads zero", rd, '0);
        read_reg(2'd0, rd); check32("R3 reserved write, sel A", rd, 32'h1234_5678);
        read_reg(2'd1, rd); check32("R3 reserved write, sel B", rd, '1);
        read_reg(2'd2, rd); check32("R3 reserved write, keep", rd, '0);

        summary();
    end

endmodule